// File: doc/BRIEF.md
# Two-Level Segmented Switch Decoder

This block turns a binary converter code into the switch controls of a segmented current-steering array, for one channel. The most significant group of code bits becomes a thermometer code that turns on full-weight unit sources. The next group becomes a second thermometer code for finer sources, each one sixteenth of a full unit. The remaining low bits pass straight through as binary-weighted controls, scaled down from the fine unit.

Each source is steered to one of two complementary output nodes, so every control line has a true (A-side) form and an inverted (B-side) form. All controls sit in one register bank, so every switch in the channel changes on the same rising clock edge. Reset forces the bank to the state for code zero. With the default widths a 10-bit code yields 15 coarse lines, 15 fine lines and 2 binary lines per side.

Top module: `segdac_switch_decoder`

## Requirements
- R1: The coarse A-side lines follow the top four code bits `code_in[9:6]` as a thermometer: for value k, lines 0 to k-1 are 1 and all others are 0, so zero turns all 15 lines off and 15 turns all on.
- R2: The fine A-side lines follow `code_in[5:2]` as a thermometer in the same way: for value k, lines 0 to k-1 are 1 and the rest 0.
- R3: The binary A-side lines copy the lowest bits: `tail_a[1]` equals `code_in[1]` (half of a fine unit) and `tail_a[0]` equals `code_in[0]` (a quarter of a fine unit).
- R4: Every B-side output is at all times the bitwise inverse of the matching A-side output.
- R5: All outputs change only on a rising clock edge, one cycle after the code is sampled; a code change between edges does not show until the next edge.
- R6: While `rst_n` is low, all A-side outputs are 0 and all B-side outputs are 1 (the code-zero state), whatever the code.
- R7: Counting a coarse line as 64, a fine line as 4, `tail_a[1]` as 2 and `tail_a[0]` as 1, the weighted sum of active A-side controls equals the registered code for every one of the 1024 codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all controls update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to the code-zero state |
| code_in | input | 10 | Binary converter code |
| coarse_a | output | 15 | Coarse unit controls, A side (thermometer) |
| coarse_b | output | 15 | Coarse unit controls, B side (inverse) |
| fine_a | output | 15 | Fine (1/16) unit controls, A side (thermometer) |
| fine_b | output | 15 | Fine unit controls, B side (inverse) |
| tail_a | output | 2 | Binary sub-unit controls, A side |
| tail_b | output | 2 | Binary sub-unit controls, B side |

## Verification
On every cycle the assertions check that the B side inverts the A side, that each thermometer field has no gaps and holds as many ones as its code segment held one cycle earlier, that the binary bits follow the delayed code, that a steady code keeps the outputs steady, and that reset holds the code-zero state. The bench's scenarios show what a per-cycle property cannot: the exact line patterns for chosen codes at the segment boundaries, that a code change stays hidden until the next edge, and that the weighted sum of active controls reproduces every one of the 1024 codes.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

  localparam int DEF_CODE_W   = 10;
  localparam int DEF_COARSE_W = 4;
  localparam int DEF_FINE_W   = 4;

  // Number of unit lines a thermometer field of w bits needs.
  function automatic int therm_lines(input int w);
    return (1 << w) - 1;
  endfunction

endpackage

// File: rtl/segdac_therm_decoder.sv
module segdac_therm_decoder #(
  parameter int SEG_W = 4
) (
  input  logic [SEG_W-1:0]        value,
  output logic [(2**SEG_W)-2:0]   lines
);

  localparam int LINES = segdac_pkg::therm_lines(SEG_W);

  // Line i is on when the segment value exceeds i.
  function automatic logic [LINES-1:0] to_therm(input logic [SEG_W-1:0] v);
    logic [LINES-1:0] t;
    for (int i = 0; i < LINES; i++) begin
      t[i] = (i < int'(v));
    end
    return t;
  endfunction

  always_comb begin
    lines = to_therm(value);
  end

endmodule

// File: rtl/segdac_ctrl_bank.sv
module segdac_ctrl_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q_true,
  output logic [WIDTH-1:0] q_comp
);

  // Both polarities are registered so the A and B sides switch together.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_true <= '0;
      q_comp <= '1;
    end else begin
      q_true <= d;
      q_comp <= ~d;
    end
  end

endmodule

// File: rtl/segdac_switch_decoder.sv
module segdac_switch_decoder #(
  parameter int CODE_W   = segdac_pkg::DEF_CODE_W,
  parameter int COARSE_W = segdac_pkg::DEF_COARSE_W,
  parameter int FINE_W   = segdac_pkg::DEF_FINE_W
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [CODE_W-1:0]                  code_in,
  output logic [(2**COARSE_W)-2:0]           coarse_a,
  output logic [(2**COARSE_W)-2:0]           coarse_b,
  output logic [(2**FINE_W)-2:0]             fine_a,
  output logic [(2**FINE_W)-2:0]             fine_b,
  output logic [CODE_W-COARSE_W-FINE_W-1:0]  tail_a,
  output logic [CODE_W-COARSE_W-FINE_W-1:0]  tail_b
);

  localparam int TAIL_W       = CODE_W - COARSE_W - FINE_W;
  localparam int COARSE_LINES = segdac_pkg::therm_lines(COARSE_W);
  localparam int FINE_LINES   = segdac_pkg::therm_lines(FINE_W);
  localparam int BANK_W       = COARSE_LINES + FINE_LINES + TAIL_W;

  // Code fields, named for the checker and for waveform reading.
  logic [COARSE_W-1:0]     coarse_sel;
  logic [FINE_W-1:0]       fine_sel;
  logic [TAIL_W-1:0]       tail_sel;
  logic [COARSE_LINES-1:0] coarse_therm;
  logic [FINE_LINES-1:0]   fine_therm;
  logic [BANK_W-1:0]       bank_d;
  logic [BANK_W-1:0]       bank_true;
  logic [BANK_W-1:0]       bank_comp;

  assign coarse_sel = code_in[CODE_W-1 -: COARSE_W];
  assign fine_sel   = code_in[TAIL_W +: FINE_W];
  assign tail_sel   = code_in[TAIL_W-1:0];

  segdac_therm_decoder #(.SEG_W(COARSE_W)) coarse_dec_i (
    .value (coarse_sel),
    .lines (coarse_therm)
  );

  segdac_therm_decoder #(.SEG_W(FINE_W)) fine_dec_i (
    .value (fine_sel),
    .lines (fine_therm)
  );

  assign bank_d = {coarse_therm, fine_therm, tail_sel};

  segdac_ctrl_bank #(.WIDTH(BANK_W)) bank_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      (bank_d),
    .q_true (bank_true),
    .q_comp (bank_comp)
  );

  assign coarse_a = bank_true[BANK_W-1 -: COARSE_LINES];
  assign fine_a   = bank_true[TAIL_W +: FINE_LINES];
  assign tail_a   = bank_true[TAIL_W-1:0];
  assign coarse_b = bank_comp[BANK_W-1 -: COARSE_LINES];
  assign fine_b   = bank_comp[TAIL_W +: FINE_LINES];
  assign tail_b   = bank_comp[TAIL_W-1:0];

endmodule

// File: rtl/segdac_switch_decoder_chk.sv
module segdac_switch_decoder_chk #(
  parameter int CODE_W   = 10,
  parameter int COARSE_W = 4,
  parameter int FINE_W   = 4
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [CODE_W-1:0]                  code_in,
  input logic [(2**COARSE_W)-2:0]           coarse_a,
  input logic [(2**COARSE_W)-2:0]           coarse_b,
  input logic [(2**FINE_W)-2:0]             fine_a,
  input logic [(2**FINE_W)-2:0]             fine_b,
  input logic [CODE_W-COARSE_W-FINE_W-1:0]  tail_a,
  input logic [CODE_W-COARSE_W-FINE_W-1:0]  tail_b
);

  localparam int TAIL_W = CODE_W - COARSE_W - FINE_W;
  localparam int CL     = (2**COARSE_W) - 1;
  localparam int FL     = (2**FINE_W) - 1;

  // Set by the first edge out of reset: from then on the outputs
  // reflect a decoded code rather than the reset value.
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assert_b_inverts_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_b == ~coarse_a) && (fine_b == ~fine_a) && (tail_b == ~tail_a));

  assert_coarse_gapless_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((coarse_a + CL'(1)) & coarse_a) == '0);

  assert_coarse_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> $countones(coarse_a) == int'($past(code_in[CODE_W-1 -: COARSE_W])));

  assert_fine_gapless_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((fine_a + FL'(1)) & fine_a) == '0);

  assert_fine_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> $countones(fine_a) == int'($past(code_in[TAIL_W +: FINE_W])));

  assert_tail_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> tail_a == $past(code_in[TAIL_W-1:0]));

  assert_steady_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $stable(code_in)) |=> $stable({coarse_a, fine_a, tail_a}));

  assert_reset_state_R6: assert property (@(posedge clk)
    !rst_n |=> (rst_n || (coarse_a == '0 && fine_a == '0 && tail_a == '0 &&
                          coarse_b == '1 && fine_b == '1 && tail_b == '1)));

endmodule

bind segdac_switch_decoder segdac_switch_decoder_chk #(
  .CODE_W   (CODE_W),
  .COARSE_W (COARSE_W),
  .FINE_W   (FINE_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .code_in  (code_in),
  .coarse_a (coarse_a),
  .coarse_b (coarse_b),
  .fine_a   (fine_a),
  .fine_b   (fine_b),
  .tail_a   (tail_a),
  .tail_b   (tail_b)
);

// File: tb/segdac_switch_decoder_tb.sv
module segdac_switch_decoder_tb_top;

  logic        clk;
  logic        rst_n;
  logic [9:0]  code_in;
  logic [14:0] coarse_a, coarse_b, fine_a, fine_b;
  logic [1:0]  tail_a, tail_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  segdac_switch_decoder dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_in  (code_in),
    .coarse_a (coarse_a),
    .coarse_b (coarse_b),
    .fine_a   (fine_a),
    .fine_b   (fine_b),
    .tail_a   (tail_a),
    .tail_b   (tail_b)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {code, coarse count, fine count, tail bits}
  localparam logic [19:0] VEC [13] = '{
    {10'h000, 4'd0,  4'd0,  2'd0},
    {10'h3FF, 4'd15, 4'd15, 2'd3},
    {10'h040, 4'd1,  4'd0,  2'd0},
    {10'h03C, 4'd0,  4'd15, 2'd0},
    {10'h003, 4'd0,  4'd0,  2'd3},
    {10'h001, 4'd0,  4'd0,  2'd1},
    {10'h002, 4'd0,  4'd0,  2'd2},
    {10'h200, 4'd8,  4'd0,  2'd0},
    {10'h155, 4'd5,  4'd5,  2'd1},
    {10'h2AA, 4'd10, 4'd10, 2'd2},
    {10'h3C0, 4'd15, 4'd0,  2'd0},
    {10'h07F, 4'd1,  4'd15, 2'd3},
    {10'h1E4, 4'd7,  4'd9,  2'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int weighted_sum();
    return 64 * $countones(coarse_a) + 4 * $countones(fine_a)
           + 2 * int'(tail_a[1]) + int'(tail_a[0]);
  endfunction

  task automatic check_inverse(input string req);
    check(coarse_b == ~coarse_a, req, int'(coarse_b), int'(~coarse_a));
    check(fine_b == ~fine_a, req, int'(fine_b), int'(~fine_a));
    check(tail_b == ~tail_a, req, int'(tail_b), int'(~tail_a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    code_in = 10'h3FF;
    repeat (3) @(negedge clk);

    // R6: reset holds code-zero state despite a full-scale code
    check(coarse_a == '0 && fine_a == '0 && tail_a == '0, "R6 A side in reset",
          int'({coarse_a, fine_a, tail_a}), 0);
    check(coarse_b == '1 && fine_b == '1 && tail_b == '1, "R6 B side in reset",
          int'({coarse_b, fine_b, tail_b}), 32'hFFFFFFFF);

    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: R1 coarse lines, R2 fine lines, R3 tail, R4 inverse
    foreach (VEC[i]) begin
      logic [9:0] c;
      logic [14:0] exp_c, exp_f;
      c     = VEC[i][19:10];
      exp_c = 15'((32'd1 << VEC[i][9:6]) - 1);
      exp_f = 15'((32'd1 << VEC[i][5:2]) - 1);
      code_in = c;
      @(negedge clk);
      check(coarse_a == exp_c, "R1 coarse thermometer", int'(coarse_a), int'(exp_c));
      check(fine_a == exp_f, "R2 fine thermometer", int'(fine_a), int'(exp_f));
      check(tail_a == VEC[i][1:0], "R3 binary tail", int'(tail_a), int'(VEC[i][1:0]));
      check_inverse("R4 complement");
    end

    // R5: a code change between edges stays hidden until the next edge
    code_in = 10'h000;
    @(negedge clk);
    code_in = 10'h3FF;
    #2;
    check(coarse_a == '0 && fine_a == '0 && tail_a == '0, "R5 no change before edge",
          int'({coarse_a, fine_a, tail_a}), 0);
    @(negedge clk);
    check(coarse_a == '1 && fine_a == '1 && tail_a == '1, "R5 change after one edge",
          int'({coarse_a, fine_a, tail_a}), 32'hFFFFFFFF);

    // R7: weighted sum reproduces every code
    for (int c = 0; c < 1024; c++) begin
      code_in = 10'(c);
      @(negedge clk);
      check(weighted_sum() == c, "R7 weighted sum", weighted_sum(), c);
      check(coarse_b == ~coarse_a && fine_b == ~fine_a && tail_b == ~tail_a,
            "R4 complement sweep", int'({coarse_b, fine_b, tail_b}),
            int'(~{coarse_a, fine_a, tail_a}));
    end

    // R6: reset reapplied mid-run returns to code-zero state
    code_in = 10'h2AA;
    rst_n = 1'b0;
    #1;
    check(weighted_sum() == 0, "R6 reset mid-run", weighted_sum(), 0);
    check(coarse_b == '1 && fine_b == '1 && tail_b == '1, "R6 B side mid-run",
          int'({coarse_b, fine_b, tail_b}), 32'hFFFFFFFF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(weighted_sum() == 10'h2AA, "R7 after reset release", weighted_sum(), 10'h2AA);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule